// File: doc/BRIEF.md
# Serial Transmitter with Commanded Line Break

This block turns bytes into asynchronous serial frames on a single output line. Each frame has a low start bit, the data bits least significant first, an optional parity bit and one or more high stop bits. The rate is set by an external one-cycle baud enable pulse, and every bit lasts exactly one pulse interval. A one-entry holding stage in front of the shift stage lets software queue the next byte while the current one is still going out.

The same control word can also ask for a line break. A break is scheduled like a character. It waits for the character in flight to finish, then holds the line low for at least one full frame time. Once the break has been cancelled and that minimum has been met, the line is held high for a recovery gap of max(12, guard) bit times before normal traffic resumes. The command rules are strict. A command arriving while the ready flag is low is dropped. A second start during a break is dropped. A stop with no break running is dropped. A word that asks for both is dropped.

Top module: `uart_brk_tx`

## Requirements
- R1: With the default parameters, a frame is 11 bit times long. It has a 0 start bit, 8 data bits least significant first, an even parity bit (XOR of the data bits), then a 1 stop bit. A frame starts on a baud pulse edge, each bit lasts one pulse interval, and the idle line is 1.
- R2: A byte write takes effect only while `tx_ready_o` is 1. `tx_ready_o` then stays 0 until the shift stage takes the byte. If a byte is already waiting when a frame ends, its start bit follows the previous stop bit directly.
- R3: `tx_empty_o` is 1 only when the holding stage is empty, no frame is being sent and no break phase is active. It is 1 after reset.
- R4: A start-break command sets bit 9 of `cmd_i` and clears bit 10. When it is accepted, `tx_ready_o` goes to 0 until the break begins. A character already being shifted out finishes before the line goes low.
- R5: During a break the line stays 0 and `tx_empty_o` stays 0. The line is low for at least 11 baud pulses. If the stop arrives before that, it is low for exactly 11.
- R6: A stop-break command sets bit 10 and clears bit 9. It is accepted while the break is low and `tx_ready_o` is 1. After the low phase the line is held high for max(12, `tguard_i`) baud pulses, with `tx_ready_o` and `tx_empty_o` both 0. After that, both flags return to 1.
- R7: A start-break command issued while a break is low is ignored and does not lengthen the break.
- R8: A stop-break command issued when no break was accepted is ignored. The line stays 1 and `tx_ready_o` stays 1.
- R9: A control word with bits 9 and 10 both set is ignored and starts no break.
- R10: A command written while `tx_ready_o` is 0 is ignored. For example, a start-break sent while a byte is waiting in the holding stage starts no break.
- R11: A byte written while a break is pending, low or recovering is discarded, and no frame for it ever appears.
- R12: A `tguard_i` value above 12 sets the length of the recovery gap, for example 20 pulses for a value of 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle bit-rate enable |
| cmd_we_i | input | 1 | Control word strobe |
| cmd_i | input | 16 | Control word; bit 9 start break, bit 10 stop break |
| tguard_i | input | 8 | Minimum recovery gap after a break, in bit times |
| thr_we_i | input | 1 | Byte write strobe |
| thr_data_i | input | 8 | Byte to send |
| txd_o | output | 1 | Serial line |
| tx_ready_o | output | 1 | A byte or command may be written |
| tx_empty_o | output | 1 | Nothing queued, shifting or in a break |

## Verification
The bench starts a break while a character is still being shifted out. A design that pulled the line low too early would corrupt that frame, which the bench catches by decoding it. The bench counts baud pulses through the low phase and the recovery gap, for both the 12-pulse floor and a larger guard value. A design that cut either phase short, or that let a repeated start-break extend the low phase, would give a wrong count. Orphan stop commands, words with both command bits set, and commands sent while a byte is waiting are all followed by long idle watches. Bytes are written during the pending, low and recovering phases, and the bench then looks for a stray frame afterwards. Any of these mistakes would show up as a low level on an idle line.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  typedef enum logic [2:0] {
    BRK_IDLE,
    BRK_PEND,
    BRK_LOW,
    BRK_LOW_STOP,
    BRK_GUARD
  } brk_state_e;

  localparam int unsigned CMD_START_IDX  = 9;
  localparam int unsigned CMD_STOP_IDX   = 10;
  localparam int unsigned GUARD_MIN_BITS = 12;

  function automatic int unsigned frame_bits(int unsigned dw, bit par_en, int unsigned stop_n);
    return 1 + dw + (par_en ? 1 : 0) + stop_n;
  endfunction

endpackage

// File: rtl/uart_brk_thr.sv
module uart_brk_thr #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (wr_i) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  AST_THR_NO_CLOBBER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_q); // R2

  AST_TAKE_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q); // R2

endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift
  import uart_brk_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter bit          PARITY_EN  = 1'b1,
  parameter bit          PARITY_ODD = 1'b0,
  parameter int unsigned STOP_BITS  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_ok_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              last_o,
  output logic              line_o
);

  localparam int unsigned FRAME_W = frame_bits(DATA_W, PARITY_EN, STOP_BITS);
  localparam int unsigned CNT_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame_w;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;
  logic               slot_free;

  if (PARITY_EN) begin : g_par
    assign frame_w = {{STOP_BITS{1'b1}}, (^data_i) ^ PARITY_ODD, data_i, 1'b0};
  end else begin : g_nopar
    assign frame_w = {{STOP_BITS{1'b1}}, data_i, 1'b0};
  end

  assign last_o    = busy_q && (cnt_q == CNT_W'(FRAME_W - 1));
  assign slot_free = !busy_q || last_o;
  assign take_o    = tick_i && slot_free && avail_i && load_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (slot_free) begin
        if (take_o) begin
          busy_q <= 1'b1;
          sh_q   <= frame_w;
          cnt_q  <= '0;
        end else begin
          busy_q <= 1'b0;
          sh_q   <= '1;
        end
      end else begin
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign line_o = busy_q ? sh_q[0] : 1'b1;

  AST_BIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> $stable(line_o)); // R1

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !line_o); // R1

endmodule

// File: rtl/uart_brk_ctrl.sv
module uart_brk_ctrl
  import uart_brk_pkg::*;
#(
  parameter int unsigned CMD_W   = 16,
  parameter int unsigned TG_W    = 8,
  parameter int unsigned FRAME_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [TG_W-1:0]  tguard_i,
  input  logic             thr_full_i,
  input  logic             shift_busy_i,
  input  logic             shift_last_i,
  output logic             ready_o,
  output logic             start_acc_o,
  output logic             brk_low_o,
  output logic             brk_idle_o
);

  localparam int unsigned LO_W = $clog2(FRAME_W + 1);

  brk_state_e      st_q, st_d;
  logic [LO_W-1:0] lo_cnt_q;
  logic [TG_W-1:0] g_cnt_q, glen_q, guard_len_w;
  logic            cmd_start, cmd_stop, stop_acc, begin_brk, lo_full, guard_done, enter_guard;
  logic            cmd_unused;

  assign cmd_unused = ^{cmd_i[CMD_W-1:CMD_STOP_IDX+1], cmd_i[CMD_START_IDX-1:0]};

  // both bits set decodes to neither command
  assign cmd_start = cmd_we_i && cmd_i[CMD_START_IDX] && !cmd_i[CMD_STOP_IDX];
  assign cmd_stop  = cmd_we_i && cmd_i[CMD_STOP_IDX] && !cmd_i[CMD_START_IDX];

  assign ready_o     = !thr_full_i && (st_q == BRK_IDLE || st_q == BRK_LOW);
  assign start_acc_o = ready_o && cmd_start && (st_q == BRK_IDLE);
  assign stop_acc    = ready_o && cmd_stop && (st_q == BRK_LOW);
  assign begin_brk   = (st_q == BRK_PEND) && tick_i && (!shift_busy_i || shift_last_i);
  assign lo_full     = lo_cnt_q == LO_W'(FRAME_W);
  assign guard_done  = g_cnt_q == glen_q;
  assign enter_guard = (st_q == BRK_LOW_STOP) && lo_full;
  assign guard_len_w = (tguard_i > TG_W'(GUARD_MIN_BITS)) ? tguard_i : TG_W'(GUARD_MIN_BITS);

  always_comb begin
    st_d = st_q;
    case (st_q)
      BRK_IDLE:     if (start_acc_o) st_d = BRK_PEND;
      BRK_PEND:     if (begin_brk)   st_d = BRK_LOW;
      BRK_LOW:      if (stop_acc)    st_d = BRK_LOW_STOP;
      BRK_LOW_STOP: if (lo_full)     st_d = BRK_GUARD;
      BRK_GUARD:    if (guard_done)  st_d = BRK_IDLE;
      default:                       st_d = BRK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= BRK_IDLE;
      lo_cnt_q <= '0;
      g_cnt_q  <= '0;
      glen_q   <= TG_W'(GUARD_MIN_BITS);
    end else begin
      st_q <= st_d;
      if (begin_brk) begin
        lo_cnt_q <= '0;
      end else if ((st_q == BRK_LOW || st_q == BRK_LOW_STOP) && tick_i && !lo_full) begin
        lo_cnt_q <= lo_cnt_q + LO_W'(1);
      end
      if (enter_guard) begin
        g_cnt_q <= '0;
        glen_q  <= guard_len_w;
      end else if ((st_q == BRK_GUARD) && tick_i && !guard_done) begin
        g_cnt_q <= g_cnt_q + TG_W'(1);
      end
    end
  end

  assign brk_low_o  = (st_q == BRK_LOW) || (st_q == BRK_LOW_STOP);
  assign brk_idle_o = (st_q == BRK_IDLE);

  AST_BEGIN_AFTER_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BRK_LOW && $past(st_q) == BRK_PEND) |-> !shift_busy_i); // R4

  AST_LOW_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BRK_GUARD && $past(st_q) == BRK_LOW_STOP) |-> $past(lo_cnt_q) == LO_W'(FRAME_W)); // R5

  AST_GUARD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BRK_IDLE && $past(st_q) == BRK_GUARD) |-> $past(g_cnt_q) >= TG_W'(GUARD_MIN_BITS)); // R6

  AST_NO_THR_IN_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != BRK_IDLE && $past(st_q) != BRK_IDLE) |-> !thr_full_i); // R11

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter bit          PARITY_EN  = 1'b1,
  parameter bit          PARITY_ODD = 1'b0,
  parameter int unsigned STOP_BITS  = 1,
  parameter int unsigned CMD_W      = 16,
  parameter int unsigned TG_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [TG_W-1:0]   tguard_i,
  input  logic              thr_we_i,
  input  logic [DATA_W-1:0] thr_data_i,
  output logic              txd_o,
  output logic              tx_ready_o,
  output logic              tx_empty_o
);

  localparam int unsigned FRAME_W = frame_bits(DATA_W, PARITY_EN, STOP_BITS);

  logic              thr_full, thr_wr, thr_take;
  logic [DATA_W-1:0] thr_q;
  logic              shift_busy, shift_last, shift_line;
  logic              start_acc, brk_low, brk_idle;

  // byte writes only land while no break phase is active
  assign thr_wr = thr_we_i && tx_ready_o && brk_idle && !start_acc;

  uart_brk_thr #(.DATA_W(DATA_W)) u_thr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (thr_wr),
    .data_i (thr_data_i),
    .take_i (thr_take),
    .full_o (thr_full),
    .data_o (thr_q)
  );

  uart_brk_shift #(
    .DATA_W     (DATA_W),
    .PARITY_EN  (PARITY_EN),
    .PARITY_ODD (PARITY_ODD),
    .STOP_BITS  (STOP_BITS)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (baud_tick_i),
    .load_ok_i (brk_idle),
    .avail_i   (thr_full),
    .data_i    (thr_q),
    .take_o    (thr_take),
    .busy_o    (shift_busy),
    .last_o    (shift_last),
    .line_o    (shift_line)
  );

  uart_brk_ctrl #(
    .CMD_W   (CMD_W),
    .TG_W    (TG_W),
    .FRAME_W (FRAME_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (baud_tick_i),
    .cmd_we_i     (cmd_we_i),
    .cmd_i        (cmd_i),
    .tguard_i     (tguard_i),
    .thr_full_i   (thr_full),
    .shift_busy_i (shift_busy),
    .shift_last_i (shift_last),
    .ready_o      (tx_ready_o),
    .start_acc_o  (start_acc),
    .brk_low_o    (brk_low),
    .brk_idle_o   (brk_idle)
  );

  assign txd_o      = shift_line && !brk_low;
  assign tx_empty_o = !thr_full && !shift_busy && brk_idle;

  AST_EMPTY_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o); // R3

  AST_LOAD_ONLY_OUTSIDE_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shift_busy) |-> $past(brk_idle)); // R11

  AST_NO_SHIFT_DURING_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_low |-> !shift_busy); // R4

endmodule

// File: tb/uart_brk_tx_test.sv
module uart_brk_tx_test;

  localparam int FB = 11;
  localparam int NV = 7;
  localparam logic [7:0] VEC_D [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80, 8'h7F, 8'h3C};
  localparam logic       VEC_P [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

  logic        clk, rst_ni, baud_tick, cmd_we, thr_we;
  logic [15:0] cmd;
  logic [7:0]  tguard, thr_data;
  logic        txd, ready, empty;
  int          n_chk, n_bad;
  bit          done;

  uart_brk_tx uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .baud_tick_i (baud_tick),
    .cmd_we_i    (cmd_we),
    .cmd_i       (cmd),
    .tguard_i    (tguard),
    .thr_we_i    (thr_we),
    .thr_data_i  (thr_data),
    .txd_o       (txd),
    .tx_ready_o  (ready),
    .tx_empty_o  (empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    int div;
    div = 0;
    baud_tick = 1'b0;
    forever begin
      @(posedge clk);
      div = (div + 1) % 4;
      baud_tick <= (div == 0);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] exp_frame(input logic [7:0] d, input logic p);
    return {1'b1, p, d, 1'b0};
  endfunction

  task automatic send_byte(input logic [7:0] d);
    do @(negedge clk); while (ready !== 1'b1);
    thr_we = 1'b1; thr_data = d;
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic poke_byte(input logic [7:0] d);
    @(negedge clk);
    thr_we = 1'b1; thr_data = d;
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic send_cmd(input logic [15:0] v);
    @(negedge clk);
    cmd_we = 1'b1; cmd = v;
    @(negedge clk);
    cmd_we = 1'b0; cmd = '0;
  endtask

  task automatic capture(output logic [FB-1:0] fr);
    int i;
    fr = '0;
    while (txd !== 1'b0) @(negedge clk);
    i = 0;
    while (i < FB) begin
      if (baud_tick === 1'b1) begin
        fr[i] = txd;
        i++;
      end
      if (i < FB) @(negedge clk);
    end
  endtask

  task automatic measure_low(output int n);
    while (txd !== 1'b0) @(negedge clk);
    n = 0;
    while (txd === 1'b0) begin
      if (baud_tick === 1'b1) n++;
      @(negedge clk);
    end
  endtask

  task automatic measure_guard(output int n, output int saw_flag);
    n = 0; saw_flag = 0;
    while (ready !== 1'b1) begin
      if (baud_tick === 1'b1 && txd === 1'b1) n++;
      if (empty === 1'b1 || txd !== 1'b1) saw_flag = 1;
      @(negedge clk);
    end
  endtask

  task automatic watch_idle(input int clocks, output int lows, output int not_ready);
    lows = 0; not_ready = 0;
    for (int k = 0; k < clocks; k++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
      if (ready !== 1'b1) not_ready++;
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [FB-1:0] fr, fr2;
    int nlow, ngap, flag, lows, nrdy;
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_ni = 1'b0; cmd_we = 1'b0; cmd = '0; thr_we = 1'b0; thr_data = '0; tguard = 8'd5;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R3 reset txd", 32'(txd), 32'd1);
    check("R3 reset ready", 32'(ready), 32'd1);
    check("R3 reset empty", 32'(empty), 32'd1);

    // R1 vector table
    for (int v = 0; v < NV; v++) begin
      fork
        send_byte(VEC_D[v]);
        capture(fr);
      join
      check("R1 frame", 32'(fr), 32'(exp_frame(VEC_D[v], VEC_P[v])));
      repeat (2) @(negedge clk);
      check("R3 empty after frame", 32'(empty), 32'd1);
    end

    // R2 back-to-back, R10 start while byte waiting
    fork
      begin
        send_byte(8'h11);
        send_byte(8'h22);
        check("R2 ready low while held", 32'(ready), 32'd0);
        check("R3 empty low while busy", 32'(empty), 32'd0);
        send_cmd(16'h0200);
      end
      capture(fr);
    join
    check("R2 first frame", 32'(fr), 32'(exp_frame(8'h11, 1'b0)));
    @(negedge clk);
    check("R2 next start immediate", 32'(txd), 32'd0);
    capture(fr2);
    check("R2 second frame", 32'(fr2), 32'(exp_frame(8'h22, 1'b0)));
    watch_idle(80, lows, nrdy);
    check("R10 no break from blocked start", 32'(lows), 32'd0);
    check("R3 empty after pair", 32'(empty), 32'd1);

    // R8 orphan stop
    send_cmd(16'h0400);
    watch_idle(60, lows, nrdy);
    check("R8 orphan stop line", 32'(lows), 32'd0);
    check("R8 orphan stop ready", 32'(nrdy), 32'd0);

    // R9 both bits
    send_cmd(16'h0600);
    watch_idle(60, lows, nrdy);
    check("R9 both bits line", 32'(lows), 32'd0);
    check("R9 both bits ready", 32'(nrdy), 32'd0);

    // R4 break behind a character, R7 duplicate, R11 discarded writes, R6 guard floor
    tguard = 8'd5;
    fork
      begin
        capture(fr);
        check("R4 char completes first", 32'(fr), 32'(exp_frame(8'h5A, 1'b0)));
        measure_low(nlow);
        check("R5 low length", 32'(nlow), 32'd11);
        check("R7 duplicate ignored", 32'(nlow), 32'd11);
        measure_guard(ngap, flag);
        check("R6 guard floor", 32'(ngap), 32'd12);
        check("R6 empty and line during guard", 32'(flag), 32'd0);
        check("R6 empty after guard", 32'(empty), 32'd1);
      end
      begin
        send_byte(8'h5A);
        do @(negedge clk); while (ready !== 1'b1);
        send_cmd(16'h0200);
        check("R4 ready low while pending", 32'(ready), 32'd0);
        check("R5 empty low while pending", 32'(empty), 32'd0);
        poke_byte(8'h33);
        do @(negedge clk); while (ready !== 1'b1);
        check("R5 line low at break", 32'(txd), 32'd0);
        poke_byte(8'h44);
        send_cmd(16'h0200);
        send_cmd(16'h0400);
      end
    join
    watch_idle(100, lows, nrdy);
    check("R11 discarded bytes", 32'(lows), 32'd0);

    // R12 larger guard with a long break
    tguard = 8'd20;
    send_cmd(16'h0200);
    check("R4 ready low after idle start", 32'(ready), 32'd0);
    fork
      measure_low(nlow);
      begin
        do @(negedge clk); while (ready !== 1'b1);
        repeat (120) @(negedge clk);
        send_cmd(16'h0400);
      end
    join
    check("R5 long break held", 32'(nlow >= 30), 32'd1);
    measure_guard(ngap, flag);
    check("R12 guard from register", 32'(ngap), 32'd20);
    check("R12 flags during guard", 32'(flag), 32'd0);

    fork
      send_byte(8'hC3);
      capture(fr);
    join
    check("R6 normal after break", 32'(fr), 32'(exp_frame(8'hC3, 1'b0)));
    repeat (4) @(negedge clk);
    report();
  end

endmodule